// File: doc/BRIEF.md
# Cascaded Two-Stage Pulse Generator

This block joins two 8-bit down-counting channels into one long-period pulse generator. The first, prescaling stage counts count-clock strobes. Each time its counter runs out, it sends a one-cycle tick to the second stage. The second stage counts those ticks and drives a low/high output waveform. The length of each phase of that waveform is the product of the prescaler segment length and the second-stage count.

The prescaler chooses its reload value according to the second stage's phase. It uses the low-phase prescale value while the output is low and the high-phase prescale value while the output is high. The prescaler drives a pin of its own, which toggles on every tick. Four 8-bit reload inputs set the waveform. The pair runs only while both channel enables are set. A system integrator uses the block to make slow PWM or timing waveforms from a fast count clock without a 16-bit counter.

Top module: `casc_pulse_gen`

## Requirements
- R1: After reset, with both enables low, `pre_pin`, `out_pin` and `stage_tick` are 0, even while `cnt_en` is 1.
- R2: The pair runs only while `lo_run_en` and `hi_run_en` are both 1. In a cycle where either is 0, `stage_tick` is 0 and both pins are 0 after the following clock edge. The next enable starts a fresh low phase of full length.
- R3: `stage_tick` is 1 only in a cycle where `cnt_en` is 1 and the pair runs. One low phase of `out_pin` holds exactly `out_lo_rl`+1 ticks.
- R4: Counted from the start of a low phase, the first tick falls on strobe number `pre_lo_rl`+1. Counted from the start of a high phase, it falls on strobe number `pre_hi_rl`+1.
- R5: `pre_pin` is 0 when the pair is enabled. It inverts at the clock edge that ends each tick cycle and holds at every other edge.
- R6: `out_pin` (0 = low phase) stays 0 for exactly (`pre_lo_rl`+1)×(`out_lo_rl`+1) strobes. It rises at the edge that ends the last of those strobes.
- R7: `out_pin` then stays 1 for exactly (`pre_hi_rl`+1)×(`out_hi_rl`+1) strobes and returns to 0. The two phases repeat.
- R8: The second-stage count is taken when a phase starts. Changing `out_lo_rl` during a low phase leaves that phase's length unchanged. The next low phase uses the new value.
- R9: A reload value of 0 gives a one-strobe segment. A value of 255 gives 256 strobes.
- R10: A cycle with `cnt_en` low produces no tick and changes neither pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-clock strobe, one per count period |
| lo_run_en | input | 1 | Enable of the prescaling channel |
| hi_run_en | input | 1 | Enable of the output channel |
| pre_lo_rl | input | 8 | Prescaler reload used during the low phase |
| pre_hi_rl | input | 8 | Prescaler reload used during the high phase |
| out_lo_rl | input | 8 | Second-stage tick count for the low phase |
| out_hi_rl | input | 8 | Second-stage tick count for the high phase |
| pre_pin | output | 1 | Prescaler waveform, toggles per tick |
| out_pin | output | 1 | Long-period output waveform |
| stage_tick | output | 1 | Prescaler expiry tick to the second stage |

## Verification
A wrong prescaler count shows at the ports within one segment, at most 256 strobes: `stage_tick` and the edges of `pre_pin` move. A wrong second-stage count or phase cannot be seen until the phase ends. It shows as a misplaced `out_pin` edge up to 65,536 strobes later. For that reason the bench measures whole phases, and the checker ties each `out_pin` edge to a tick. The bench also observes the prescaler's reload choice through the strobe position of the first tick in each phase.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  function automatic phase_e phase_flip(input phase_e p);
    return (p == PH_LOW) ? PH_HIGH : PH_LOW;
  endfunction
endpackage

// File: rtl/cpg_prescale_stage.sv
module cpg_prescale_stage
  import cpg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         strobe,
  input  phase_e       phase_nx,
  input  logic [W-1:0] lo_rl,
  input  logic [W-1:0] hi_rl,
  output logic         tick,
  output logic         pin
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         pin_q, pin_d;

  // expiry: last strobe of the current segment
  assign tick = run & strobe & (cnt_q == '0);
  assign pin  = pin_q;

  always_comb begin
    cnt_d = cnt_q;
    pin_d = pin_q;
    if (!run) begin
      cnt_d = lo_rl;
      pin_d = 1'b0;
    end else if (strobe) begin
      if (cnt_q == '0) begin
        cnt_d = (phase_nx == PH_HIGH) ? hi_rl : lo_rl;
        pin_d = ~pin_q;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pin_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pin_q <= pin_d;
    end
  end
endmodule

// File: rtl/cpg_phase_stage.sv
module cpg_phase_stage
  import cpg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] lo_rl,
  input  logic [W-1:0] hi_rl,
  output phase_e       phase_q,
  output phase_e       phase_nx
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         expire;

  assign expire = tick & (cnt_q == '0);

  always_comb begin
    phase_nx = phase_q;
    cnt_d    = cnt_q;
    if (!run) begin
      phase_nx = PH_LOW;
      cnt_d    = lo_rl;
    end else if (tick) begin
      if (expire) begin
        phase_nx = phase_flip(phase_q);
        cnt_d    = (phase_nx == PH_HIGH) ? hi_rl : lo_rl;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= PH_LOW;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_nx;
    end
  end
endmodule

// File: rtl/casc_pulse_gen.sv
module casc_pulse_gen
  import cpg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         lo_run_en,
  input  logic         hi_run_en,
  input  logic [W-1:0] pre_lo_rl,
  input  logic [W-1:0] pre_hi_rl,
  input  logic [W-1:0] out_lo_rl,
  input  logic [W-1:0] out_hi_rl,
  output logic         pre_pin,
  output logic         out_pin,
  output logic         stage_tick
);
  logic   run;
  phase_e phase_q, phase_nx;

  assign run = lo_run_en & hi_run_en;

  cpg_prescale_stage #(.W(W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .strobe   (cnt_en),
    .phase_nx (phase_nx),
    .lo_rl    (pre_lo_rl),
    .hi_rl    (pre_hi_rl),
    .tick     (stage_tick),
    .pin      (pre_pin)
  );

  cpg_phase_stage #(.W(W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (stage_tick),
    .lo_rl    (out_lo_rl),
    .hi_rl    (out_hi_rl),
    .phase_q  (phase_q),
    .phase_nx (phase_nx)
  );

  assign out_pin = (phase_q == PH_HIGH);
endmodule

// File: rtl/cpg_checker.sv
module cpg_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         lo_run_en,
  input logic         hi_run_en,
  input logic [W-1:0] pre_lo_rl,
  input logic [W-1:0] pre_hi_rl,
  input logic [W-1:0] out_lo_rl,
  input logic [W-1:0] out_hi_rl,
  input logic         pre_pin,
  input logic         out_pin,
  input logic         stage_tick
);
  // R2
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_run_en && hi_run_en) |=> (!pre_pin && !out_pin));

  // R2
  no_tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_run_en && hi_run_en) |-> !stage_tick);

  // R10
  tick_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |-> !stage_tick);

  // R5
  pre_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_tick |=> (pre_pin != $past(pre_pin)));

  // R5
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_run_en && hi_run_en && !stage_tick) |=> $stable(pre_pin));

  // R6
  out_edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_run_en && hi_run_en && !stage_tick) |=> $stable(out_pin));
endmodule

bind casc_pulse_gen cpg_checker #(.W(W)) u_cpg_chk (.*);

// File: tb/tb_casc_pulse_gen.sv
`timescale 1ns/100ps
module tb_casc_pulse_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cnt_en, lo_run_en, hi_run_en;
  logic [7:0] pre_lo_rl, pre_hi_rl, out_lo_rl, out_hi_rl;
  logic       pre_pin, out_pin, stage_tick;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  casc_pulse_gen dut (.*);

  // Ln, Hn, Lm, Hm, strobe gap, expected low strobes, expected high strobes
  // vectors 3 and 4 hold the R9 extremes 0 and 255
  localparam int NV = 5;
  localparam int VEC [NV][7] = '{
    '{  0,   0, 0, 0, 1,   1,   1},
    '{  2,   1, 3, 0, 2,  12,   2},
    '{  4,   6, 1, 2, 3,  10,  21},
    '{255,   0, 1, 0, 1, 512,   1},
    '{  0, 255, 0, 2, 2,   1, 768}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts strobes while out_pin == lvl; called and returns at a negedge
  task automatic measure(input logic lvl, input int gap, output int strobes,
                         output int ticks, output int first_tick);
    strobes = 0; ticks = 0; first_tick = 0;
    while (out_pin == lvl && strobes < 2000) begin
      cnt_en = 1'b1;
      #0.5;
      if (stage_tick) begin
        ticks++;
        if (first_tick == 0) first_tick = strobes + 1;
      end
      @(negedge clk);
      cnt_en = 1'b0;
      strobes++;
      for (int g = 1; g < gap; g++) @(negedge clk);
    end
  endtask

  task automatic setup(input int ln, input int hn, input int lm, input int hm);
    lo_run_en = 1'b0; hi_run_en = 1'b0; cnt_en = 1'b0;
    pre_lo_rl = 8'(ln); pre_hi_rl = 8'(hn);
    out_lo_rl = 8'(lm); out_hi_rl = 8'(hm);
    @(negedge clk);
    @(negedge clk);
    lo_run_en = 1'b1; hi_run_en = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s, t, f;
    rst_n = 1'b0; cnt_en = 1'b1; lo_run_en = 1'b0; hi_run_en = 1'b0;
    pre_lo_rl = 8'd1; pre_hi_rl = 8'd1; out_lo_rl = 8'd1; out_hi_rl = 8'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: pins and tick low after reset, strobe high, pair disabled
    chk(!pre_pin && !out_pin && !stage_tick, "R1 reset outputs",
        {pre_pin, out_pin, stage_tick}, 0);

    for (int v = 0; v < NV; v++) begin
      setup(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      // R5: prescaler pin low at enable
      chk(pre_pin == 1'b0, "R5 pre_pin at enable", pre_pin, 0);
      measure(1'b0, VEC[v][4], s, t, f);
      chk(s == VEC[v][5], "R6 low phase strobes", s, VEC[v][5]);
      chk(t == VEC[v][2] + 1, "R3 ticks in low phase", t, VEC[v][2] + 1);
      chk(f == VEC[v][0] + 1, "R4 first low tick", f, VEC[v][0] + 1);
      chk(pre_pin == 1'((VEC[v][2] + 1) % 2), "R5 pre_pin parity", pre_pin,
          (VEC[v][2] + 1) % 2);
      measure(1'b1, VEC[v][4], s, t, f);
      chk(s == VEC[v][6], "R7 high phase strobes", s, VEC[v][6]);
      chk(f == VEC[v][1] + 1, "R4 first high tick", f, VEC[v][1] + 1);
      measure(1'b0, VEC[v][4], s, t, f);
      chk(s == VEC[v][5], "R6 repeated low phase", s, VEC[v][5]);
    end

    // R9: reload 255 gives 256 strobes before the first tick
    setup(255, 0, 0, 0);
    measure(1'b0, 1, s, t, f);
    chk(f == 256, "R9 255 reload segment", f, 256);

    // R10: idle cycles with cnt_en low change nothing
    setup(2, 0, 1, 0);
    for (int i = 0; i < 40; i++) begin
      #0.5;
      if (stage_tick) chk(1'b0, "R10 tick without strobe", 1, 0);
      @(negedge clk);
    end
    chk(!pre_pin && !out_pin, "R10 pins held", {pre_pin, out_pin}, 0);
    measure(1'b0, 1, s, t, f);
    chk(s == 6, "R10 low phase after idle", s, 6);

    // R2: disable mid-phase forces pins low, re-enable restarts the low phase
    setup(3, 0, 3, 0);
    for (int i = 0; i < 5; i++) begin
      cnt_en = 1'b1; @(negedge clk);
    end
    cnt_en = 1'b0;
    chk(pre_pin == 1'b1, "R5 pre_pin after first segment", pre_pin, 1);
    lo_run_en = 1'b0;
    cnt_en = 1'b1;
    #0.5;
    chk(!stage_tick, "R2 no tick while disabled", stage_tick, 0);
    @(negedge clk);
    cnt_en = 1'b0;
    chk(!pre_pin && !out_pin, "R2 pins low when disabled", {pre_pin, out_pin}, 0);
    lo_run_en = 1'b1;
    measure(1'b0, 1, s, t, f);
    chk(s == 16, "R2 full low phase after re-enable", s, 16);
    // R2: dropping the other enable during the high phase
    chk(out_pin == 1'b1, "R2 high phase reached", out_pin, 1);
    hi_run_en = 1'b0;
    @(negedge clk);
    chk(!out_pin, "R2 out_pin low after hi enable drop", out_pin, 0);

    // R8: second-stage low count changed mid-phase
    setup(1, 0, 3, 0);
    cnt_en = 1'b1; @(negedge clk); cnt_en = 1'b0;
    out_lo_rl = 8'd0;
    measure(1'b0, 1, s, t, f);
    chk(s + 1 == 8, "R8 current low phase unchanged", s + 1, 8);
    measure(1'b1, 1, s, t, f);
    chk(s == 1, "R7 high phase in R8 test", s, 1);
    measure(1'b0, 1, s, t, f);
    chk(s == 2, "R8 next low phase uses new count", s, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule